// File: doc/BRIEF.md
# DRAM Precharge Timing Tracker

This block watches the command stream of one DRAM channel and reports, for every rank and bank, whether a PRECHARGE may be issued in the current DRAM clock. It holds a 16-bit timing word that software programs. The word sets four minimum spacings. Three of them are measured per rank and bank, from the last ACTIVATE, the last WRITE and the last READ. The fourth is measured per rank, from the last PRECHARGE to any bank of that rank.

A scheduler reads the `pre_ok` vector before it picks a PRECHARGE. Each command is given as a valid strobe, a 2-bit type, a rank and a bank. If a PRECHARGE arrives while its target is still blocked, a sticky flag records the error.

Top module: `pchg_timing_tracker`

## Requirements
- R1: The timing word resets to 0000h. A write through `cfg_we` is visible on `cfg_rdata` after the next clock. Its fields are: bits 15:11 ACT-to-PRE, bits 10:6 WRITE-to-PRE, bits 5:2 READ-to-PRE, bits 1:0 PRE-to-PRE.
- R2: After an ACT (type 00) to rank r, bank b, issued at clock edge t, `pre_ok[r*8+b]` is low until the cycle that begins at edge t+N. Here N is the ACT-to-PRE field, and the output is high from that cycle on.
- R3: The same rule applies after a WRITE (type 10) to rank r, bank b, using the WRITE-to-PRE field.
- R4: The same rule applies after a READ (type 01) to rank r, bank b, using the READ-to-PRE field.
- R5: A PRE (type 11) to rank r, to any bank, holds every bit of rank r low under the same rule, using the PRE-to-PRE field. Other ranks are not affected.
- R6: A field value of 0 or 1 adds no wait. The elapsed-time counters saturate, so a target stays permitted however long it stays idle after its wait has passed.
- R7: Each `pre_ok` bit is the AND of all four constraints that apply to it.
- R8: A PRE to a target whose `pre_ok` bit is low sets `pre_violation` at the next edge. The flag then stays high until reset. That PRE still restarts its rank's PRE-to-PRE spacing.
- R9: A new timing word takes effect one clock after the write. It applies to spacings that are already counting.
- R10: While `cmd_valid` is low, commands have no effect on `pre_ok` or `pre_violation`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the timing word |
| cfg_wdata | input | 16 | Timing word to write |
| cfg_rdata | output | 16 | Current timing word |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_type | input | 2 | 00 ACT, 01 READ, 10 WRITE, 11 PRE |
| cmd_rank | input | 2 | Target rank |
| cmd_bank | input | 3 | Target bank |
| pre_ok | output | 32 | PRECHARGE permitted, bit index rank*8+bank |
| pre_violation | output | 1 | Sticky flag for a PRE to a blocked target |

## Verification
Two functions can act in the same edge. One is a timing-word write that tightens or loosens limits while counters are running. The other is a PRE that is judged against the current permission and also restarts the rank spacing. The bench provokes both with directed steps: a write in the middle of a count, and a PRE issued to a blocked bank. It also scatters them through random traffic that writes new timing words at random. A bench model keeps unbounded elapsed counts and applies each write at the same edge as the design. The bench compares all 32 permission bits, the violation flag and the read-back word in every cycle.

// File: rtl/pchg_pkg.sv
// Package: shared types for the precharge timing tracker.
// Assumes the 16-bit timing word layout below; field order in the struct
// follows bit position (most significant first).
package pchg_pkg;

    typedef enum logic [1:0] {
        CMD_ACT = 2'b00,
        CMD_RD  = 2'b01,
        CMD_WR  = 2'b10,
        CMD_PRE = 2'b11
    } cmd_kind_e;

    localparam int ACT_LIM_W = 5;
    localparam int WR_LIM_W  = 5;
    localparam int RD_LIM_W  = 4;
    localparam int PP_LIM_W  = 2;
    localparam int CFG_W     = ACT_LIM_W + WR_LIM_W + RD_LIM_W + PP_LIM_W;

    typedef struct packed {
        logic [ACT_LIM_W-1:0] act2pre;  // bits 15:11
        logic [WR_LIM_W-1:0]  wr2pre;   // bits 10:6
        logic [RD_LIM_W-1:0]  rd2pre;   // bits 5:2
        logic [PP_LIM_W-1:0]  pre2pre;  // bits 1:0
    } timing_cfg_t;

endpackage

// File: rtl/pchg_cfg_reg.sv
// Module: timing word register.
// Holds the programmed spacings. A write lands at the clock edge and
// is seen by the trackers from the following cycle. Resets to zero.
module pchg_cfg_reg
    import pchg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output timing_cfg_t      cfg
);

    // Capture a new timing word, or clear it in reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  cfg <= '0;
        else if (we) cfg <= timing_cfg_t'(wdata);
    end

    // R1
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg == timing_cfg_t'($past(wdata))));

endmodule

// File: rtl/pchg_sat_counter.sv
// Module: saturating elapsed-clock counter.
// Reports the clocks elapsed since the last restart. A restart sets it to 1,
// which covers the edge after the command. It stops at all-ones and never
// wraps. After reset it sits at all-ones, meaning "long ago".
module pchg_sat_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ONE  = W'(1);

    // Restart on a command, otherwise count up until saturated.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= MAXV;
        else if (restart)      cnt <= ONE;
        else if (cnt != MAXV)  cnt <= cnt + ONE;
    end

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && !restart) |=> (cnt == MAXV));

    // R2
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == ONE));

endmodule

// File: rtl/pchg_bank_tracker.sv
// Module: per rank-bank spacing tracker.
// Keeps the elapsed clocks since the last ACT, WRITE and READ to one bank,
// and compares each with its programmed minimum. The limits come straight
// from the timing register, so a new word applies to running counts.
module pchg_bank_tracker
    import pchg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit_act,
    input  logic                 hit_wr,
    input  logic                 hit_rd,
    input  logic [ACT_LIM_W-1:0] lim_act,
    input  logic [WR_LIM_W-1:0]  lim_wr,
    input  logic [RD_LIM_W-1:0]  lim_rd,
    output logic                 bank_ok
);

    logic [ACT_LIM_W-1:0] act_cnt;
    logic [WR_LIM_W-1:0]  wr_cnt;
    logic [RD_LIM_W-1:0]  rd_cnt;

    pchg_sat_counter #(.W(ACT_LIM_W)) u_act (
        .clk(clk), .rst_n(rst_n), .restart(hit_act), .cnt(act_cnt));
    pchg_sat_counter #(.W(WR_LIM_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .restart(hit_wr), .cnt(wr_cnt));
    pchg_sat_counter #(.W(RD_LIM_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .restart(hit_rd), .cnt(rd_cnt));

    // Bank side of the permission: all three per-bank spacings met.
    always_comb begin
        bank_ok = (act_cnt >= lim_act) && (wr_cnt >= lim_wr) && (rd_cnt >= lim_rd);
    end

    // R2
    act_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_act && !$changed(lim_act) && lim_act > ACT_LIM_W'(1)) |=>
            (!bank_ok || lim_act != $past(lim_act)));

endmodule

// File: rtl/pchg_rank_tracker.sv
// Module: per rank PRE-to-PRE tracker.
// Counts the clocks since the last PRE to any bank of the rank and
// compares the count with the programmed PRE-to-PRE minimum.
module pchg_rank_tracker
    import pchg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit_pre,
    input  logic [PP_LIM_W-1:0] lim_pp,
    output logic                rank_ok
);

    logic [PP_LIM_W-1:0] pp_cnt;

    pchg_sat_counter #(.W(PP_LIM_W)) u_pp (
        .clk(clk), .rst_n(rst_n), .restart(hit_pre), .cnt(pp_cnt));

    // Rank side of the permission.
    always_comb begin
        rank_ok = (pp_cnt >= lim_pp);
    end

endmodule

// File: rtl/pchg_timing_tracker.sv
// Module: top of the precharge timing tracker.
// Decodes each valid command into a hit on one bank tracker (ACT, WRITE,
// READ) or one rank tracker (PRE). Combines the bank and rank results into
// the per-target permission vector, and latches a sticky flag when a PRE
// hits a blocked target. Assumes at most one command per clock.
module pchg_timing_tracker
    import pchg_pkg::*;
#(
    parameter int NUM_RANKS = 4,
    parameter int NUM_BANKS = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [15:0]                    cfg_wdata,
    output logic [15:0]                    cfg_rdata,
    input  logic                           cmd_valid,
    input  logic [1:0]                     cmd_type,
    input  logic [$clog2(NUM_RANKS)-1:0]   cmd_rank,
    input  logic [$clog2(NUM_BANKS)-1:0]   cmd_bank,
    output logic [NUM_RANKS*NUM_BANKS-1:0] pre_ok,
    output logic                           pre_violation
);

    localparam int NUM_TGT = NUM_RANKS * NUM_BANKS;
    localparam int TGT_W   = $clog2(NUM_TGT);

    timing_cfg_t          cfg;
    cmd_kind_e            kind;
    logic [TGT_W-1:0]     tgt_idx;
    logic [NUM_RANKS-1:0] rank_ok;
    logic [NUM_RANKS-1:0] rank_sel;
    logic [NUM_TGT-1:0]   tgt_sel;
    logic                 is_act, is_wr, is_rd, is_pre;

    pchg_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg));

    assign cfg_rdata = cfg;

    // Decode the command type and the flat target index.
    always_comb begin
        kind    = cmd_kind_e'(cmd_type);
        is_act  = cmd_valid && (kind == CMD_ACT);
        is_wr   = cmd_valid && (kind == CMD_WR);
        is_rd   = cmd_valid && (kind == CMD_RD);
        is_pre  = cmd_valid && (kind == CMD_PRE);
        tgt_idx = TGT_W'(cmd_rank) * TGT_W'(NUM_BANKS) + TGT_W'(cmd_bank);
    end

    generate
        for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
            assign rank_sel[r] = (cmd_rank == r[$clog2(NUM_RANKS)-1:0]);

            pchg_rank_tracker u_rank (
                .clk(clk), .rst_n(rst_n),
                .hit_pre(is_pre && rank_sel[r]),
                .lim_pp(cfg.pre2pre),
                .rank_ok(rank_ok[r]));

            for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
                localparam int IDX = r * NUM_BANKS + b;
                logic bank_ok;

                assign tgt_sel[IDX] = rank_sel[r] &&
                                      (cmd_bank == b[$clog2(NUM_BANKS)-1:0]);

                pchg_bank_tracker u_bank (
                    .clk(clk), .rst_n(rst_n),
                    .hit_act(is_act && tgt_sel[IDX]),
                    .hit_wr(is_wr && tgt_sel[IDX]),
                    .hit_rd(is_rd && tgt_sel[IDX]),
                    .lim_act(cfg.act2pre),
                    .lim_wr(cfg.wr2pre),
                    .lim_rd(cfg.rd2pre),
                    .bank_ok(bank_ok));

                // Final permission: bank spacings AND rank spacing.
                assign pre_ok[IDX] = bank_ok && rank_ok[r];
            end
        end
    endgenerate

    // Latch a PRE that targets a blocked rank-bank; hold until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                         pre_violation <= 1'b0;
        else if (is_pre && !pre_ok[tgt_idx]) pre_violation <= 1'b1;
    end

    // R8
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_violation |=> pre_violation);

    // R8
    viol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pre && !pre_ok[tgt_idx]) |=> pre_violation);

    // R5
    pp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pre && !cfg_we && cfg.pre2pre > 2'd1) |=> !pre_ok[$past(tgt_idx)]);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !pre_violation) |=> !pre_violation);

endmodule

// File: tb/pchg_timing_tracker_test.sv
module pchg_timing_tracker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_type = '0;
    logic [1:0]  cmd_rank = '0;
    logic [2:0]  cmd_bank = '0;
    logic [31:0] pre_ok;
    logic        pre_violation;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // Model state: unbounded elapsed counts (capped far above any limit).
    int e_act [32];
    int e_wr  [32];
    int e_rd  [32];
    int e_pp  [4];
    logic [15:0] m_cfg = '0;
    logic        m_viol = 1'b0;

    pchg_timing_tracker uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
        .cmd_rank(cmd_rank), .cmd_bank(cmd_bank), .pre_ok(pre_ok),
        .pre_violation(pre_violation));

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected < 150000", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    function automatic logic exp_ok(input int i);
        return (e_act[i] >= int'(m_cfg[15:11])) && (e_wr[i] >= int'(m_cfg[10:6])) &&
               (e_rd[i] >= int'(m_cfg[5:2]))   && (e_pp[i/8] >= int'(m_cfg[1:0]));
    endfunction

    function automatic logic [31:0] exp_vec();
        logic [31:0] v;
        for (int i = 0; i < 32; i++) v[i] = exp_ok(i);
        return v;
    endfunction

    function automatic int bump(input int x);
        return (x >= 1000) ? 1000 : x + 1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 32; i++) begin
            e_act[i] = 1000; e_wr[i] = 1000; e_rd[i] = 1000;
        end
        for (int r = 0; r < 4; r++) e_pp[r] = 1000;
        m_cfg = '0;
        m_viol = 1'b0;
    endtask

    task automatic check_all(input string req);
        logic [31:0] ev;
        ev = exp_vec();
        n_checks++;
        if (pre_ok !== ev) begin
            n_fail++;
            $display("FAIL %s pre_ok: actual %h expected %h", req, pre_ok, ev);
        end
        n_checks++;
        if (pre_violation !== m_viol) begin
            n_fail++;
            $display("FAIL %s pre_violation: actual %b expected %b", req, pre_violation, m_viol);
        end
        n_checks++;
        if (cfg_rdata !== m_cfg) begin
            n_fail++;
            $display("FAIL %s cfg_rdata: actual %h expected %h", req, cfg_rdata, m_cfg);
        end
    endtask

    // Apply one cycle of stimulus (called at a negedge), then check at the next negedge.
    task automatic step(input logic v, input logic [1:0] t, input logic [1:0] r,
                        input logic [2:0] b, input logic we, input logic [15:0] wd,
                        input string req);
        int idx;
        idx = int'(r) * 8 + int'(b);
        cmd_valid = v; cmd_type = t; cmd_rank = r; cmd_bank = b;
        cfg_we = we; cfg_wdata = wd;
        if (v && t == 2'b11 && !exp_ok(idx)) m_viol = 1'b1;
        for (int i = 0; i < 32; i++) begin
            e_act[i] = bump(e_act[i]); e_wr[i] = bump(e_wr[i]); e_rd[i] = bump(e_rd[i]);
        end
        for (int k = 0; k < 4; k++) e_pp[k] = bump(e_pp[k]);
        if (v) begin
            case (t)
                2'b00: e_act[idx] = 1;
                2'b01: e_rd[idx]  = 1;
                2'b10: e_wr[idx]  = 1;
                default: e_pp[int'(r)] = 1;
            endcase
        end
        if (we) m_cfg = wd;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; cfg_we = 1'b0;
        check_all(req);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(1'b0, 2'b00, 2'd0, 3'd0, 1'b0, 16'h0, req);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_all("R1 reset");

        // R1: write and read back a field pattern
        step(1'b0, 2'b00, 2'd0, 3'd0, 1'b1, {5'd5, 5'd0, 4'd0, 2'd0}, "R1");
        // R2: ACT spacing of 5 on rank 1 bank 3
        step(1'b1, 2'b00, 2'd1, 3'd3, 1'b0, 16'h0, "R2");
        idle(6, "R2");
        // R3: WRITE spacing of 7
        step(1'b0, 2'b00, 2'd0, 3'd0, 1'b1, {5'd0, 5'd7, 4'd0, 2'd0}, "R3");
        step(1'b1, 2'b10, 2'd2, 3'd6, 1'b0, 16'h0, "R3");
        idle(8, "R3");
        // R4: READ spacing of 15
        step(1'b0, 2'b00, 2'd0, 3'd0, 1'b1, {5'd0, 5'd0, 4'd15, 2'd0}, "R4");
        step(1'b1, 2'b01, 2'd3, 3'd7, 1'b0, 16'h0, "R4");
        idle(16, "R4");
        // R5: PRE-to-PRE of 3, legal PREs, whole rank blocked
        step(1'b0, 2'b00, 2'd0, 3'd0, 1'b1, {5'd0, 5'd0, 4'd0, 2'd3}, "R5");
        step(1'b1, 2'b11, 2'd0, 3'd2, 1'b0, 16'h0, "R5");
        idle(3, "R5");
        step(1'b1, 2'b11, 2'd0, 3'd5, 1'b0, 16'h0, "R5");
        idle(3, "R5");
        // R6: values of 1 add no wait
        step(1'b0, 2'b00, 2'd0, 3'd0, 1'b1, {5'd1, 5'd1, 4'd1, 2'd1}, "R6");
        step(1'b1, 2'b00, 2'd1, 3'd1, 1'b0, 16'h0, "R6");
        step(1'b1, 2'b11, 2'd1, 3'd1, 1'b0, 16'h0, "R6");
        step(1'b1, 2'b11, 2'd1, 3'd2, 1'b0, 16'h0, "R6");
        // R6: saturation at the 31 maximum, long idle stays permitted
        step(1'b0, 2'b00, 2'd0, 3'd0, 1'b1, {5'd31, 5'd31, 4'd15, 2'd3}, "R6");
        step(1'b1, 2'b10, 2'd2, 3'd2, 1'b0, 16'h0, "R6");
        idle(70, "R6");
        // R9: tighten a running count, then loosen it
        step(1'b0, 2'b00, 2'd0, 3'd0, 1'b1, {5'd4, 5'd0, 4'd0, 2'd0}, "R9");
        step(1'b1, 2'b00, 2'd0, 3'd4, 1'b0, 16'h0, "R9");
        step(1'b0, 2'b00, 2'd0, 3'd0, 1'b1, {5'd20, 5'd0, 4'd0, 2'd0}, "R9");
        idle(4, "R9");
        step(1'b0, 2'b00, 2'd0, 3'd0, 1'b1, {5'd2, 5'd0, 4'd0, 2'd0}, "R9");
        idle(2, "R9");
        // R10: invalid ACT does not block, invalid PRE to a blocked bank does not flag
        step(1'b0, 2'b00, 2'd3, 3'd3, 1'b1, {5'd10, 5'd0, 4'd0, 2'd0}, "R10");
        step(1'b0, 2'b00, 2'd3, 3'd3, 1'b0, 16'h0, "R10");
        step(1'b1, 2'b00, 2'd3, 3'd0, 1'b0, 16'h0, "R10");
        step(1'b0, 2'b11, 2'd3, 3'd0, 1'b0, 16'h0, "R10");
        idle(2, "R10");
        // R8: PRE to the blocked bank flags, stays flagged, restarts PRE spacing
        step(1'b0, 2'b00, 2'd0, 3'd0, 1'b1, {5'd10, 5'd0, 4'd0, 2'd3}, "R8");
        step(1'b1, 2'b11, 2'd3, 3'd0, 1'b0, 16'h0, "R8");
        idle(12, "R8");

        // R7: random traffic with random timing words
        for (int n = 0; n < 4000; n++) begin
            logic [15:0] wd;
            logic        we;
            we = ($urandom % 40) == 0;
            wd = 16'($urandom);
            if (($urandom % 3) != 0) wd = wd & 16'b00111_00011_0011_11;
            step(($urandom % 3) != 0, 2'($urandom), 2'($urandom), 3'($urandom),
                 we, wd, "R7");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule